// File: doc/BRIEF.md
# Pipelined Complex Radix-2 Butterfly

This block is the arithmetic core of a radix-2 FFT engine for a 256-point transform. Each cycle it can take two complex data words, A and B, and a complex twiddle factor W from a sinusoid table. It returns the two butterfly results, A + W·B and A − W·B, both scaled by one half. Every complex value is a 32-bit word made of two signed 16-bit fixed-point parts. The twiddle is read as a Q1.15 fraction.

The work runs through three register stages. The first stage latches the four real partial products. The second combines them into the rotated operand W·B, rounds it to nearest, and clamps it to 16 bits. The third adds and subtracts, then halves both results so their size stays bounded from one FFT pass to the next. A valid bit moves along with the data. There is no stall and no backpressure, so a caller can stream one butterfly per clock and collect each result a fixed three cycles later.

Top module: `cplx_butterfly`

## Requirements
- R1: Every complex port word carries the real part in bits [31:16] and the imaginary part in bits [15:0], both two's complement.
- R2: The real part of the rotated operand is P_re = floor((br·wr − bi·wi + 2^14) / 2^15). This is round-to-nearest, and a tie rounds upward.
- R3: The imaginary part of the rotated operand is P_im = floor((br·wi + bi·wr + 2^14) / 2^15), with the same rounding as R2.
- R4: A rotated component outside [−32768, 32767] is clamped to the nearer limit before the add and subtract.
- R5: out_sum components equal floor((a + P) / 2), computed per component.
- R6: out_dif components equal floor((a − P) / 2), computed per component.
- R7: A butterfly accepted with in_valid high in cycle n shows out_valid high with its results in cycle n+3.
- R8: Butterflies issued on back-to-back cycles each come out on consecutive cycles, with no stall or loss.
- R9: While rst_n is low, out_valid is low. After release, out_valid stays low until a newly accepted butterfly has passed through all three stages.
- R10: A cycle with in_valid low produces a cycle with out_valid low three cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the valid pipeline |
| in_valid | input | 1 | A butterfly is presented this cycle |
| in_a | input | 32 | Operand A, {re, im} |
| in_b | input | 32 | Operand B, {re, im} |
| in_w | input | 32 | Twiddle W as a Q1.15 fraction, {re, im} |
| out_valid | output | 1 | Results are valid this cycle |
| out_sum | output | 32 | (A + W·B) / 2, {re, im} |
| out_dif | output | 32 | (A − W·B) / 2, {re, im} |

## Verification
The bench first streams the full cross product of five corner values (−32768, −1, 0, 1, 32767) over all six input components, back to back. This grid separates the cross-term signs of the complex product, the clamp at the product extremes, and floor versus truncation in the final halving of negative odd values. Directed vectors then apply an exact rounding tie to each product part, which exposes a missing or misplaced rounding offset, and a unit real input, which shows any swap of the word halves. A pseudo-random stream with irregular valid gaps and a reset in the middle of traffic checks that the valid bit keeps its place against the data and that nothing stale is released after reset.

// File: rtl/cplx_butterfly.sv
module cplx_butterfly #(
  parameter int CW   = 16,
  parameter int FRAC = CW - 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [2*CW-1:0] in_a,
  input  logic [2*CW-1:0] in_b,
  input  logic [2*CW-1:0] in_w,
  output logic            out_valid,
  output logic [2*CW-1:0] out_sum,
  output logic [2*CW-1:0] out_dif
);
  localparam int PW = 2 * CW;
  localparam int SW = PW + 1;
  localparam int RW = SW - FRAC;
  localparam logic signed [SW-1:0] HALF = SW'(1) << (FRAC - 1);
  localparam logic signed [RW-1:0] MAXV = RW'((2 ** (CW - 1)) - 1);
  localparam logic signed [RW-1:0] MINV = RW'(-(2 ** (CW - 1)));

  function automatic logic signed [CW-1:0] clamp(input logic signed [RW-1:0] x);
    if (x > MAXV) return MAXV[CW-1:0];
    if (x < MINV) return MINV[CW-1:0];
    return x[CW-1:0];
  endfunction

  logic signed [CW-1:0] br, bi, wr, wi;
  assign br = in_b[PW-1:CW];
  assign bi = in_b[CW-1:0];
  assign wr = in_w[PW-1:CW];
  assign wi = in_w[CW-1:0];

  // stage 1: four partial products
  logic                 v1;
  logic signed [PW-1:0] prr, pii, pri, pir;
  logic [PW-1:0]        a1;
  always_ff @(posedge clk) begin
    prr <= br * wr;
    pii <= bi * wi;
    pri <= br * wi;
    pir <= bi * wr;
    a1  <= in_a;
  end

  // stage 2: combine, round, clamp
  logic signed [SW-1:0] acc_re, acc_im;
  assign acc_re = SW'(prr) - SW'(pii) + HALF;
  assign acc_im = SW'(pri) + SW'(pir) + HALF;

  logic                 v2;
  logic signed [CW-1:0] m_re, m_im;
  logic [PW-1:0]        a2;
  always_ff @(posedge clk) begin
    m_re <= clamp(acc_re[SW-1:FRAC]);
    m_im <= clamp(acc_im[SW-1:FRAC]);
    a2   <= a1;
  end

  // stage 3: add, subtract, halve
  logic signed [CW:0] a2_re, a2_im, s_re, s_im, d_re, d_im;
  assign a2_re = (CW+1)'($signed(a2[PW-1:CW]));
  assign a2_im = (CW+1)'($signed(a2[CW-1:0]));
  assign s_re  = a2_re + (CW+1)'(m_re);
  assign s_im  = a2_im + (CW+1)'(m_im);
  assign d_re  = a2_re - (CW+1)'(m_re);
  assign d_im  = a2_im - (CW+1)'(m_im);

  always_ff @(posedge clk) begin
    out_sum <= {s_re[CW:1], s_im[CW:1]};
    out_dif <= {d_re[CW:1], d_im[CW:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1        <= 1'b0;
      v2        <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      v1        <= in_valid;
      v2        <= v1;
      out_valid <= v2;
    end
  end

  // checks
  logic signed [CW:0] pair_re, pair_im;
  assign pair_re = (CW+1)'($signed(out_sum[PW-1:CW])) + (CW+1)'($signed(out_dif[PW-1:CW]));
  assign pair_im = (CW+1)'($signed(out_sum[CW-1:0])) + (CW+1)'($signed(out_dif[CW-1:0]));

  p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##3 out_valid);

  p_bubble_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> ##3 !out_valid);

  p_halves_re_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (pair_re == $past(a2_re) || pair_re == $past(a2_re) - 1));

  p_halves_im_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (pair_im == $past(a2_im) || pair_im == $past(a2_im) - 1));

  p_reset_r9: assert property (@(posedge clk)
    !rst_n |=> !out_valid);
endmodule

// File: tb/tb_cplx_butterfly.sv
`timescale 1ns/1ps
module tb_cplx_butterfly;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_a = '0, in_b = '0, in_w = '0;
  logic        out_valid;
  logic [31:0] out_sum, out_dif;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cplx_butterfly dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_a(in_a), .in_b(in_b), .in_w(in_w),
    .out_valid(out_valid), .out_sum(out_sum), .out_dif(out_dif)
  );

  logic        hv[3];
  logic [31:0] hs[3], hd[3];
  string       ht[3];

  function automatic int sat16(input longint x);
    if (x > 32767) return 32767;
    if (x < -32768) return -32768;
    return int'(x);
  endfunction

  function automatic logic [63:0] model(input logic [31:0] a, input logic [31:0] b, input logic [31:0] w);
    longint ar = longint'($signed(a[31:16]));
    longint ai = longint'($signed(a[15:0]));
    longint br = longint'($signed(b[31:16]));
    longint bi = longint'($signed(b[15:0]));
    longint wr = longint'($signed(w[31:16]));
    longint wi = longint'($signed(w[15:0]));
    longint pr = longint'(sat16((br * wr - bi * wi + 16384) >>> 15));
    longint pi = longint'(sat16((br * wi + bi * wr + 16384) >>> 15));
    longint sr = (ar + pr) >>> 1;
    longint si = (ai + pi) >>> 1;
    longint dr = (ar - pr) >>> 1;
    longint di = (ai - pi) >>> 1;
    return {sr[15:0], si[15:0], dr[15:0], di[15:0]};
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_out();
    if (hv[2]) begin
      chk(out_valid === 1'b1, ht[2], "out_valid", 32'(out_valid), 32'd1);
      chk(out_sum === hs[2], ht[2], "out_sum", out_sum, hs[2]);
      chk(out_dif === hd[2], ht[2], "out_dif", out_dif, hd[2]);
    end else begin
      chk(out_valid === 1'b0, ht[2], "out_valid", 32'(out_valid), 32'd0);
    end
  endtask

  task automatic clear_hist(input string tag);
    for (int k = 0; k < 3; k++) begin
      hv[k] = 1'b0; hs[k] = '0; hd[k] = '0; ht[k] = tag;
    end
  endtask

  task automatic step(input logic v, input logic [31:0] a, input logic [31:0] b,
                      input logic [31:0] w, input string tag);
    logic [63:0] e;
    check_out();
    e = model(a, b, w);
    for (int k = 2; k > 0; k--) begin
      hv[k] = hv[k-1]; hs[k] = hs[k-1]; hd[k] = hd[k-1]; ht[k] = ht[k-1];
    end
    hv[0] = v; hs[0] = e[63:32]; hd[0] = e[31:0]; ht[0] = tag;
    in_valid = v; in_a = a; in_b = b; in_w = w;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R7 actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int vals[5] = '{-32768, -1, 0, 1, 32767};
    logic [31:0] st = 32'h1234_5678;
    clear_hist("R9");
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0, "R9", "out_valid in reset", 32'(out_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: unit real operand lands in upper half
    step(1, {16'd100, 16'd0}, 32'd0, 32'd0, "R1");
    step(1, {16'd0, 16'd100}, 32'd0, 32'd0, "R1");
    // R2 / R3: exact ties round upward
    step(1, 32'd0, {16'd1, 16'd0}, {16'd16384, 16'd0}, "R2");
    step(1, 32'd0, {16'd0, 16'd1}, {16'd16384, 16'd0}, "R3");
    step(1, 32'd0, {16'd16384, 16'd0}, {16'd16384, 16'd16384}, "R3");
    // R4: products at the limits
    step(1, 32'd0, 32'h8000_8000, 32'h8000_7fff, "R4");
    step(1, 32'h7fff_8000, 32'h8000_8000, 32'h8000_8000, "R4");
    step(0, 32'd0, 32'd0, 32'd0, "R10");

    // R5 / R6 / R8: corner grid, streamed back to back
    for (int i0 = 0; i0 < 5; i0++)
      for (int i1 = 0; i1 < 5; i1++)
        for (int i2 = 0; i2 < 5; i2++)
          for (int i3 = 0; i3 < 5; i3++)
            for (int i4 = 0; i4 < 5; i4++)
              for (int i5 = 0; i5 < 5; i5++)
                step(1, {vals[i0][15:0], vals[i1][15:0]}, {vals[i2][15:0], vals[i3][15:0]},
                     {vals[i4][15:0], vals[i5][15:0]}, (i5 % 2) ? "R6" : "R8");

    // R7 / R10: random traffic with gaps
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] a, b, w;
      st ^= st << 13; st ^= st >> 17; st ^= st << 5; a = st;
      st ^= st << 13; st ^= st >> 17; st ^= st << 5; b = st;
      st ^= st << 13; st ^= st >> 17; st ^= st << 5; w = st;
      if (st[9:8] != 2'b00) step(1, a, b, w, "R7");
      else step(0, a, b, w, "R10");
    end

    // R9: reset during traffic drops everything in flight
    step(1, 32'h1111_2222, 32'h3333_4444, 32'h5555_6666, "R9");
    step(1, 32'h7777_0001, 32'h0002_0003, 32'h4000_c000, "R9");
    rst_n = 1'b0;
    in_valid = 1'b1;
    @(negedge clk);
    chk(out_valid === 1'b0, "R9", "out_valid in reset", 32'(out_valid), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    clear_hist("R9");
    repeat (3) step(0, 32'd0, 32'd0, 32'd0, "R9");
    step(1, {16'd2, 16'hfffe}, {16'd16384, 16'd0}, {16'h7fff, 16'd0}, "R9");
    repeat (3) step(0, 32'd0, 32'd0, 32'd0, "R10");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule